// File: doc/BRIEF.md
# Configurable-Aspect Single-Port Block RAM

This block is a single-port synchronous memory holding 16,384 data bits and 2,048 parity bits. A parameter fixes the word width, and the depth and address width follow from it. In the shapes whose word is a whole number of bytes, every word carries a parity lane of one bit per data byte. The memory has no parity generator or checker. The parity lane is plain extra storage that is written and read together with the data.

Each rising clock edge with the enable high performs one operation on the array and the registered output. The operation is decoded into one of four kinds: `OP_HOLD` (enable low), `OP_RESET` (set/reset high), `OP_WRITE` (write enable high) and `OP_READ` (otherwise). The output register takes its next value from that operation. A second parameter selects the write mode, which decides what the output shows during `OP_WRITE`: `WM_WRITE_FIRST` shows the new word, `WM_READ_FIRST` shows the word that was overwritten, and `WM_NO_CHANGE` keeps the previous output. The array contents start from two parameter images, one for data and one for parity. The output register starts from a parameterised reset value.

Top module: `aspect_bram`

## Requirements
- R1: `DATA_W` must be one of 1, 2, 4, 8, 16 or 32. The depth is 16384/`DATA_W` and the address width is log2 of the depth, giving 14, 13, 12, 11, 10 and 9 bits in that order.
- R2: The parity width is `DATA_W`/8 when `DATA_W` ≥ 8. The parity ports are that wide, parity bit j belongs to data byte j, and `dout_par` bit 0 is the lowest parity bit. When `DATA_W` < 8 the parity ports are one bit wide, `din_par` is ignored and `dout_par` always reads 0.
- R3: Before the first write, data word i holds bits [i*`DATA_W` +: `DATA_W`] of `INIT_DATA` and parity word i holds bits [i*PW +: PW] of `INIT_PAR`. Before the first active edge, the output holds `SR_DATA`[`DATA_W`-1:0] and `SR_PAR`[PW-1:0].
- R4: When `en`=1, `sr`=0 and `we`=0, the word at `addr` appears on `dout`/`dout_par` after the next rising edge, with a latency of one cycle.
- R5: When `en`=1 and `we`=1, `din`/`din_par` are stored at `addr` on that edge, even if `sr` is high.
- R6: When `en`=0 nothing is written and the output holds, whatever the values of `we` and `sr`.
- R7: When `en`=1 and `sr`=1 the output is loaded with the reset value of R3. This applies whether or not a write happens on the same edge.
- R8: In `WM_WRITE_FIRST` mode, which is the default, a write without `sr` drives the newly written word to the output.
- R9: In `WM_READ_FIRST` mode, a write without `sr` drives the contents held at `addr` before the write.
- R10: In `WM_NO_CHANGE` mode, a write without `sr` leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| en | input | 1 | Port enable; gates reads, writes and set/reset |
| we | input | 1 | Write enable |
| sr | input | 1 | Synchronous set/reset of the output register |
| addr | input | log2(16384/DATA_W) | Word address |
| din | input | DATA_W | Write data |
| din_par | input | max(DATA_W/8,1) | Write parity bits |
| dout | output | DATA_W | Registered read data |
| dout_par | output | max(DATA_W/8,1) | Registered read parity bits |

## Verification
The bench builds four instances side by side and drives all of them with the same stimulus:
- a 512×(32+4) instance in write-first mode,
- a 1K×(16+2) instance in read-first mode,
- a 2K×(8+1) instance in no-change mode,
- a 4K×4 instance that keeps the default mode.

Together these cover all three collision behaviours, three different parity widths, and a shape without parity, where the ignored parity input can be observed. The same address value is truncated differently by each instance, so each instance sees its own aliasing. Random traffic confined to a few addresses makes read-after-write collisions and set/reset combined with a write happen frequently.

// File: rtl/bram_cfg_pkg.sv
package bram_cfg_pkg;

    typedef enum logic [1:0] {
        WM_WRITE_FIRST,
        WM_READ_FIRST,
        WM_NO_CHANGE
    } wmode_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_RESET,
        OP_READ,
        OP_WRITE
    } op_e;

    localparam int unsigned DATA_BITS = 16384;
    localparam int unsigned PAR_BITS  = 2048;

    function automatic int unsigned par_width(input int unsigned dw);
        return (dw >= 8) ? dw / 8 : 0;
    endfunction

    function automatic int unsigned par_port_width(input int unsigned dw);
        return (dw >= 8) ? dw / 8 : 1;
    endfunction

    function automatic bit shape_legal(input int unsigned dw);
        return (dw == 1) || (dw == 2) || (dw == 4) ||
               (dw == 8) || (dw == 16) || (dw == 32);
    endfunction

endpackage

// File: rtl/bram_lane_store.sv
module bram_lane_store #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 2048,
    parameter logic [W*DEPTH-1:0] INIT = '0,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wr_word,
    output logic [W-1:0]  rd_word
);

    logic [W-1:0] cells [DEPTH];

    initial begin
        for (int i = 0; i < int'(DEPTH); i++) begin
            cells[i] = INIT[i*W +: W];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[addr] <= wr_word;
        end
    end

    assign rd_word = cells[addr];

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    // R5: a stored word is visible at the same address on the next cycle
    a_r5_store_lands: assert property (@(posedge clk) disable iff (!armed)
        wr_en |=> ((addr != $past(addr)) || (rd_word == $past(wr_word))));

endmodule

// File: rtl/bram_lane_out.sv
module bram_lane_out
    import bram_cfg_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter wmode_e      MODE  = WM_WRITE_FIRST,
    parameter logic [W-1:0] SRVAL = '0
) (
    input  logic         clk,
    input  logic         en,
    input  logic         we,
    input  logic         sr,
    input  logic [W-1:0] wr_word,
    input  logic [W-1:0] rd_word,
    output logic [W-1:0] q
);

    op_e          op;
    logic [W-1:0] q_reg = SRVAL;
    logic [W-1:0] q_nxt;

    always_comb begin
        if (!en)      op = OP_HOLD;
        else if (sr)  op = OP_RESET;
        else if (we)  op = OP_WRITE;
        else          op = OP_READ;
    end

    always_ff @(posedge clk) begin
        q_reg <= q_nxt;
    end

    always_comb begin
        q_nxt = q_reg;
        unique case (op)
            OP_HOLD:  q_nxt = q_reg;
            OP_RESET: q_nxt = SRVAL;
            OP_READ:  q_nxt = rd_word;
            OP_WRITE: begin
                unique case (MODE)
                    WM_WRITE_FIRST: q_nxt = wr_word;
                    WM_READ_FIRST:  q_nxt = rd_word;
                    WM_NO_CHANGE:   q_nxt = q_reg;
                endcase
            end
        endcase
    end

    assign q = q_reg;

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!armed)
        !en |=> $stable(q));

    a_r7_reset_value: assert property (@(posedge clk) disable iff (!armed)
        (en && sr) |=> (q == SRVAL));

    a_r4_read_latency: assert property (@(posedge clk) disable iff (!armed)
        (en && !sr && !we) |=> (q == $past(rd_word)));

    generate
        if (MODE == WM_WRITE_FIRST) begin : g_wf
            a_r8_new_word: assert property (@(posedge clk) disable iff (!armed)
                (en && !sr && we) |=> (q == $past(wr_word)));
        end else if (MODE == WM_READ_FIRST) begin : g_rf
            a_r9_old_word: assert property (@(posedge clk) disable iff (!armed)
                (en && !sr && we) |=> (q == $past(rd_word)));
        end else begin : g_nc
            a_r10_kept: assert property (@(posedge clk) disable iff (!armed)
                (en && !sr && we) |=> $stable(q));
        end
    endgenerate

endmodule

// File: rtl/aspect_bram.sv
module aspect_bram
    import bram_cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter wmode_e      MODE   = WM_WRITE_FIRST,
    parameter logic [DATA_BITS-1:0] INIT_DATA = '0,
    parameter logic [PAR_BITS-1:0]  INIT_PAR  = '0,
    parameter logic [31:0] SR_DATA = '0,
    parameter logic [3:0]  SR_PAR  = '0,
    localparam int unsigned DEPTH = DATA_BITS / DATA_W,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = par_width(DATA_W),
    localparam int unsigned PPW   = par_port_width(DATA_W)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic              sr,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] din,
    input  logic [PPW-1:0]    din_par,
    output logic [DATA_W-1:0] dout,
    output logic [PPW-1:0]    dout_par
);

    // R1: only the six supported shapes may be built
    initial begin
        a_r1_shape_legal: assert (shape_legal(DATA_W));
    end

    logic              wr_en;
    logic [DATA_W-1:0] d_rd;

    assign wr_en = en & we;

    bram_lane_store #(
        .W     (DATA_W),
        .DEPTH (DEPTH),
        .INIT  (INIT_DATA)
    ) u_data_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_word (din),
        .rd_word (d_rd)
    );

    bram_lane_out #(
        .W     (DATA_W),
        .MODE  (MODE),
        .SRVAL (SR_DATA[DATA_W-1:0])
    ) u_data_out (
        .clk     (clk),
        .en      (en),
        .we      (we),
        .sr      (sr),
        .wr_word (din),
        .rd_word (d_rd),
        .q       (dout)
    );

    generate
        if (PW > 0) begin : g_par
            logic [PW-1:0] p_rd;

            bram_lane_store #(
                .W     (PW),
                .DEPTH (DEPTH),
                .INIT  (INIT_PAR)
            ) u_par_store (
                .clk     (clk),
                .wr_en   (wr_en),
                .addr    (addr),
                .wr_word (din_par),
                .rd_word (p_rd)
            );

            bram_lane_out #(
                .W     (PW),
                .MODE  (MODE),
                .SRVAL (SR_PAR[PW-1:0])
            ) u_par_out (
                .clk     (clk),
                .en      (en),
                .we      (we),
                .sr      (sr),
                .wr_word (din_par),
                .rd_word (p_rd),
                .q       (dout_par)
            );
        end else begin : g_nopar
            logic unused_par;
            assign unused_par = ^din_par;
            assign dout_par   = '0;
        end
    endgenerate

endmodule

// File: tb/test_aspect_bram.sv
module test_aspect_bram;
    import bram_cfg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NINST = 4;

    localparam logic [16383:0] IMG_D = {4'h5, {455{36'h9E3779B97}}};
    localparam logic [2047:0]  IMG_P = {{75{27'h5A3C96F}}, 23'h1234};
    localparam logic [31:0]    SRV_D = 32'h1234_5678;
    localparam logic [3:0]     SRV_P = 4'hB;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        s_en = 1'b0, s_we = 1'b0, s_sr = 1'b0;
    logic [13:0] s_addr = '0;
    logic [31:0] s_d = '0;
    logic [3:0]  s_p = '0;

    logic [31:0] q_a; logic [3:0] qp_a;
    logic [15:0] q_b; logic [1:0] qp_b;
    logic [7:0]  q_c; logic [0:0] qp_c;
    logic [3:0]  q_d; logic [0:0] qp_d;

    aspect_bram #(.DATA_W(32), .MODE(WM_WRITE_FIRST), .INIT_DATA(IMG_D),
        .INIT_PAR(IMG_P), .SR_DATA(SRV_D), .SR_PAR(SRV_P)) i_aspect_bram (
        .clk(clk), .en(s_en), .we(s_we), .sr(s_sr), .addr(s_addr[8:0]),
        .din(s_d), .din_par(s_p), .dout(q_a), .dout_par(qp_a));

    aspect_bram #(.DATA_W(16), .MODE(WM_READ_FIRST), .INIT_DATA(IMG_D),
        .INIT_PAR(IMG_P), .SR_DATA(SRV_D), .SR_PAR(SRV_P)) i_aspect_bram_b (
        .clk(clk), .en(s_en), .we(s_we), .sr(s_sr), .addr(s_addr[9:0]),
        .din(s_d[15:0]), .din_par(s_p[1:0]), .dout(q_b), .dout_par(qp_b));

    aspect_bram #(.DATA_W(8), .MODE(WM_NO_CHANGE), .INIT_DATA(IMG_D),
        .INIT_PAR(IMG_P), .SR_DATA(SRV_D), .SR_PAR(SRV_P)) i_aspect_bram_c (
        .clk(clk), .en(s_en), .we(s_we), .sr(s_sr), .addr(s_addr[10:0]),
        .din(s_d[7:0]), .din_par(s_p[0:0]), .dout(q_c), .dout_par(qp_c));

    aspect_bram #(.DATA_W(4), .INIT_DATA(IMG_D),
        .INIT_PAR(IMG_P), .SR_DATA(SRV_D), .SR_PAR(SRV_P)) i_aspect_bram_d (
        .clk(clk), .en(s_en), .we(s_we), .sr(s_sr), .addr(s_addr[11:0]),
        .din(s_d[3:0]), .din_par(s_p[0:0]), .dout(q_d), .dout_par(qp_d));

    // behavioural reference: word = {parity, data}, data in the low bits
    int dw_c [NINST] = '{32, 16, 8, 4};
    int pw_c [NINST] = '{4, 2, 1, 0};
    int md_c [NINST] = '{0, 1, 2, 0};   // 0 write-first, 1 read-first, 2 no-change
    logic [35:0] mdl [NINST][16384];
    logic [35:0] exp_q [NINST];
    string       tag_q [NINST];

    int checks = 0;
    int errors = 0;
    logic [31:0] lfsr = 32'h1F2E_3D4C;

    function automatic logic [35:0] msk(input int n);
        return (36'd1 << n) - 36'd1;
    endfunction

    function automatic logic [35:0] got(input int k);
        case (k)
            0: return {qp_a, q_a};
            1: return 36'(q_b) | (36'(qp_b) << 16);
            2: return 36'(q_c) | (36'(qp_c) << 8);
            default: return 36'(q_d) | (36'(qp_d) << 4);
        endcase
    endfunction

    function automatic logic [35:0] srv(input int k);
        return (36'(SRV_D) & msk(dw_c[k])) | ((36'(SRV_P) & msk(pw_c[k])) << dw_c[k]);
    endfunction

    task automatic compare_all();
        for (int k = 0; k < NINST; k++) begin
            checks++;
            if (got(k) !== exp_q[k]) begin
                errors++;
                $display("FAIL %s inst%0d addr=%0h: got %h expected %h",
                         tag_q[k], k, s_addr, got(k), exp_q[k]);
            end
        end
    endtask

    task automatic step(input logic en, input logic we, input logic sr,
                        input logic [13:0] a, input logic [31:0] d, input logic [3:0] p);
        s_en = en; s_we = we; s_sr = sr; s_addr = a; s_d = d; s_p = p;
        for (int k = 0; k < NINST; k++) begin
            int          ix;
            logic [35:0] wd;
            logic [35:0] old;
            ix  = int'(a) % (16384 / dw_c[k]);
            wd  = (36'(d) & msk(dw_c[k])) | ((36'(p) & msk(pw_c[k])) << dw_c[k]);
            old = mdl[k][ix];
            if (!en) begin
                tag_q[k] = "R6 idle";
            end else if (sr) begin
                exp_q[k] = srv(k);
                tag_q[k] = we ? "R7/R5 reset+write" : "R7 reset";
            end else if (we) begin
                case (md_c[k])
                    0: begin exp_q[k] = wd;  tag_q[k] = "R8 write-first"; end
                    1: begin exp_q[k] = old; tag_q[k] = "R9 read-first"; end
                    default: tag_q[k] = "R10 no-change";
                endcase
            end else begin
                exp_q[k] = old;
                tag_q[k] = "R4/R2 read";
            end
            if (en && we) mdl[k][ix] = wd;
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R3: model contents from the images
        for (int k = 0; k < NINST; k++) begin
            for (int i = 0; i < 16384 / dw_c[k]; i++) begin
                logic [35:0] w;
                w = '0;
                for (int b = 0; b < dw_c[k]; b++) w[b] = IMG_D[i*dw_c[k] + b];
                for (int b = 0; b < pw_c[k]; b++) w[dw_c[k] + b] = IMG_P[i*pw_c[k] + b];
                mdl[k][i] = w;
            end
            exp_q[k] = srv(k);
            tag_q[k] = "R3 start value";
        end
        #1;
        compare_all();
        @(negedge clk);

        // R3/R4: initial image readback, including the top of each range
        step(1, 0, 0, 14'd0,    '0, '0);
        step(1, 0, 0, 14'd1,    '0, '0);
        step(1, 0, 0, 14'd5,    '0, '0);
        step(1, 0, 0, 14'd511,  '0, '0);
        step(1, 0, 0, 14'h3FFF, '0, '0);
        // R5 with collision per mode (R8/R9/R10), then readback
        step(1, 1, 0, 14'd3, 32'hDEAD_BEEF, 4'hA);
        step(1, 0, 0, 14'd3, '0, '0);
        // R6: disabled write is dropped and output holds
        step(0, 1, 0, 14'd3, 32'h0000_0000, 4'h0);
        step(1, 0, 0, 14'd3, '0, '0);
        // R7 + R5: reset with write, word still stored
        step(1, 1, 1, 14'd7, 32'hCAFE_F00D, 4'h5);
        step(1, 0, 0, 14'd7, '0, '0);
        // R6: reset ignored while disabled
        step(0, 0, 1, 14'd7, '0, '0);
        // overwrite: read-first shows the previous word
        step(1, 1, 0, 14'd3, 32'h0BAD_F00D, 4'h6);
        step(1, 0, 0, 14'd3, '0, '0);

        for (int n = 0; n < 3000; n++) begin
            logic [13:0] a;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            a = (lfsr[31:29] == 3'd0) ? lfsr[13:0] : {10'd0, lfsr[3:0]};
            step(lfsr[28:26] != 3'd0, lfsr[25], lfsr[24:21] == 4'd0, a,
                 {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_0F0F, lfsr[20:17]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule